// File: doc/BRIEF.md
# Supply Rail Startup and Auto-Restart Sequencer

This block runs the life cycle of a switching controller's own supply rail. It sees the rail only through digitised comparator flags: below the short-circuit level, above turn-on, below turn-off, below the switching-stop level, below the auto-restart level and below the latch-reset level. From these flags it decides four things. It chooses when the high-voltage startup path charges the rail, and whether that path uses its small or its large current. It chooses when switching may run, and how far the permitted drain current has ramped during soft-start. It also chooses when all protections are cleared again.

A fault request from the protection logic halts switching at once. With the latch strap low, recovery passes through two discharge phases. The first phase ends when the rail drops under the switching-stop level. The second phase ends at the auto-restart level, where a one-cycle protection-reset pulse is issued and charging starts over. With the strap high, the sequencer parks in a latched state. There the startup path is switched on at the auto-restart level and off at turn-on, with no switching, until the rail sinks below the latch-reset level. That only happens once input power is gone. A tick input is the time base for the soft-start ramp.

The states are CHARGE_SLOW, CHARGE_FAST, SOFTSTART, RUN, FAULT_DISCHARGE1, FAULT_DISCHARGE2 and LATCHED, each coded one-hot. The transitions are:
- CHARGE_SLOW to CHARGE_FAST when the rail clears the short level, and back when it falls below it.
- CHARGE_FAST to SOFTSTART at turn-on.
- SOFTSTART to RUN when the ramp completes.
- SOFTSTART or RUN to FAULT_DISCHARGE1 on an auto-mode fault or on undervoltage lockout.
- SOFTSTART or RUN to LATCHED on a latch-mode fault.
- FAULT_DISCHARGE1 to FAULT_DISCHARGE2 at the stop level.
- FAULT_DISCHARGE2 to CHARGE_SLOW at the restart level, with a reset pulse.
- LATCHED to CHARGE_SLOW at the latch-reset level, with a reset pulse.

Top module: `rail_life_seq`

## Requirements
- R1: Out of reset the block is in CHARGE_SLOW: hv_start_en=1, hv_cur_hi=0, sw_en=0, ss_active=0, ss_step=0, prot_reset=0.
- R2: While charging, hv_cur_hi is 0 when rail_lt_short was high at the last edge and 1 otherwise, and it follows the flag in both directions with one cycle of latency.
- R3: In CHARGE_FAST, rail_gt_on moves to SOFTSTART on the next edge: hv_start_en=0, sw_en=1, ss_active=1, ss_step=0.
- R4: In SOFTSTART, ss_step rises by one after every SS_TICKS_PER_STEP cycles with tick high; cycles without tick do not count. After SS_STEPS*SS_TICKS_PER_STEP ticks the block enters RUN with ss_active=0 and ss_step=SS_STEPS-1 (7 by default).
- R5: rail_lt_uvlo while switching (SOFTSTART or RUN) clears sw_en and hv_start_en on the next edge and enters FAULT_DISCHARGE1.
- R6: fault_req while switching with latch_mode=0 clears sw_en on the next edge and enters FAULT_DISCHARGE1. That state moves to FAULT_DISCHARGE2 only on rail_lt_stop, so rail_lt_restart seen in FAULT_DISCHARGE1 has no effect.
- R7: In FAULT_DISCHARGE2, rail_lt_restart returns the block to CHARGE_SLOW with prot_reset high for exactly that one cycle and hv_start_en=1.
- R8: fault_req while switching with latch_mode=1 enters LATCHED. There sw_en stays 0, and hv_start_en and hv_cur_hi go to 1 after rail_lt_restart and to 0 after rail_gt_on, holding their value in between.
- R9: In LATCHED, rail_lt_unlatch returns the block to CHARGE_SLOW with a one-cycle prot_reset pulse.
- R10: fault_req is ignored in CHARGE_SLOW, CHARGE_FAST, FAULT_DISCHARGE1, FAULT_DISCHARGE2 and LATCHED. The outputs are exactly those the state would show without it.
- R11: fault_req takes priority over both undervoltage lockout and soft-start completion in the same cycle. It picks its own target state from latch_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe for the soft-start ramp |
| rail_lt_short | input | 1 | Rail below the short-circuit level |
| rail_gt_on | input | 1 | Rail above the turn-on level |
| rail_lt_uvlo | input | 1 | Rail below the turn-off level |
| rail_lt_stop | input | 1 | Rail below the switching-stop level |
| rail_lt_restart | input | 1 | Rail below the auto-restart level |
| rail_lt_unlatch | input | 1 | Rail below the latch-reset level |
| fault_req | input | 1 | Fault request from protection logic |
| latch_mode | input | 1 | Strap: 1 selects latching recovery |
| hv_start_en | output | 1 | High-voltage startup path enable |
| hv_cur_hi | output | 1 | Startup current select, 1 = large |
| sw_en | output | 1 | Switching enable |
| ss_active | output | 1 | Soft-start in progress |
| ss_step | output | STEP_W (3) | Current-limit step index |
| prot_reset | output | 1 | One-cycle protection-reset pulse |

## Verification
Two events can land on the same edge. One is the tick that finishes the soft-start ramp. The other is a fault request, and separately a fault request arriving together with undervoltage lockout. The bench counts ticks so that its twenty-fourth tick and fault_req both fall on one edge, and it asserts fault_req together with a rail below the turn-off level in latch mode. A bench reference model judges each case. Only FAULT_DISCHARGE1 or LATCHED is accepted, never RUN.

// File: rtl/rail_life_pkg.sv
package rail_life_pkg;

    // One-hot supply sequencer states
    typedef enum logic [6:0] {
        CHARGE_SLOW      = 7'b0000001,
        CHARGE_FAST      = 7'b0000010,
        SOFTSTART        = 7'b0000100,
        RUN              = 7'b0001000,
        FAULT_DISCHARGE1 = 7'b0010000,
        FAULT_DISCHARGE2 = 7'b0100000,
        LATCHED          = 7'b1000000
    } seq_state_e;

endpackage

// File: rtl/rail_life_ramp.sv
// Soft-start step generator: counts time-base ticks while enabled.
module rail_life_ramp #(
    parameter int STEPS  = 8,
    parameter int TICKS  = 16,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TICKS - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             step_edge;

    assign step_edge = en && tick && (tick_cnt == CNT_LAST);
    assign done      = step_edge && (step == STEP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            step     <= '0;
        end else if (!en) begin
            tick_cnt <= '0;
            step     <= '0;
        end else if (tick) begin
            if (tick_cnt == CNT_LAST) begin
                tick_cnt <= '0;
                if (step != STEP_LAST) step <= step + 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rail_life_relatch.sv
// Startup-path hysteresis used while parked in the latched state.
module rail_life_relatch (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic below_restart,
    input  logic above_on,
    output logic hv_on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hv_on <= 1'b0;
        else if (!active)       hv_on <= 1'b0;
        else if (below_restart) hv_on <= 1'b1;
        else if (above_on)      hv_on <= 1'b0;
    end
endmodule

// File: rtl/rail_life_seq.sv
module rail_life_seq
    import rail_life_pkg::*;
#(
    parameter int SS_STEPS          = 8,
    parameter int SS_TICKS_PER_STEP = 16,
    localparam int STEP_W           = (SS_STEPS > 1) ? $clog2(SS_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rail_lt_short,
    input  logic              rail_gt_on,
    input  logic              rail_lt_uvlo,
    input  logic              rail_lt_stop,
    input  logic              rail_lt_restart,
    input  logic              rail_lt_unlatch,
    input  logic              fault_req,
    input  logic              latch_mode,
    output logic              hv_start_en,
    output logic              hv_cur_hi,
    output logic              sw_en,
    output logic              ss_active,
    output logic [STEP_W-1:0] ss_step,
    output logic              prot_reset
);
    localparam logic [STEP_W-1:0] STEP_FULL = STEP_W'(SS_STEPS - 1);

    seq_state_e        state_q, state_d;
    logic              reset_d;
    logic              ramp_done;
    logic [STEP_W-1:0] ramp_step;
    logic              latch_hv;

    rail_life_ramp #(
        .STEPS (SS_STEPS),
        .TICKS (SS_TICKS_PER_STEP),
        .STEP_W(STEP_W)
    ) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q == SOFTSTART),
        .tick (tick),
        .step (ramp_step),
        .done (ramp_done)
    );

    rail_life_relatch u_relatch (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (state_q == LATCHED),
        .below_restart(rail_lt_restart),
        .above_on     (rail_gt_on),
        .hv_on        (latch_hv)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        reset_d = 1'b0;
        unique case (state_q)
            CHARGE_SLOW: begin
                if (!rail_lt_short) state_d = CHARGE_FAST;
            end
            CHARGE_FAST: begin
                if (rail_lt_short)   state_d = CHARGE_SLOW;
                else if (rail_gt_on) state_d = SOFTSTART;
            end
            SOFTSTART, RUN: begin
                if (fault_req)
                    state_d = latch_mode ? LATCHED : FAULT_DISCHARGE1;
                else if (rail_lt_uvlo)
                    state_d = FAULT_DISCHARGE1;
                else if ((state_q == SOFTSTART) && ramp_done)
                    state_d = RUN;
            end
            FAULT_DISCHARGE1: begin
                if (rail_lt_stop) state_d = FAULT_DISCHARGE2;
            end
            FAULT_DISCHARGE2: begin
                if (rail_lt_restart) begin
                    state_d = CHARGE_SLOW;
                    reset_d = 1'b1;
                end
            end
            LATCHED: begin
                if (rail_lt_unlatch) begin
                    state_d = CHARGE_SLOW;
                    reset_d = 1'b1;
                end
            end
            default: state_d = CHARGE_SLOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CHARGE_SLOW;
            prot_reset <= 1'b0;
        end else begin
            state_q    <= state_d;
            prot_reset <= reset_d;
        end
    end

    // Output decode
    always_comb begin
        hv_start_en = 1'b0;
        hv_cur_hi   = 1'b0;
        sw_en       = 1'b0;
        ss_active   = 1'b0;
        ss_step     = '0;
        unique case (state_q)
            CHARGE_SLOW: hv_start_en = 1'b1;
            CHARGE_FAST: begin
                hv_start_en = 1'b1;
                hv_cur_hi   = 1'b1;
            end
            SOFTSTART: begin
                sw_en     = 1'b1;
                ss_active = 1'b1;
                ss_step   = ramp_step;
            end
            RUN: begin
                sw_en   = 1'b1;
                ss_step = STEP_FULL;
            end
            FAULT_DISCHARGE1, FAULT_DISCHARGE2: begin
                sw_en = 1'b0;
            end
            LATCHED: begin
                hv_start_en = latch_hv;
                hv_cur_hi   = latch_hv;
            end
            default: sw_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/rail_life_seq_chk.sv
module rail_life_seq_chk #(
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rail_lt_uvlo,
    input logic              fault_req,
    input logic              hv_start_en,
    input logic              sw_en,
    input logic              ss_active,
    input logic [STEP_W-1:0] ss_step,
    input logic              prot_reset
);
    AST_HV_SW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && hv_start_en)); // R3

    AST_STEP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active && $past(ss_active)) |-> (ss_step >= $past(ss_step))); // R4

    AST_UVLO_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && rail_lt_uvlo) |=> !sw_en); // R5

    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && fault_req) |=> !sw_en); // R6

    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_reset |=> !prot_reset); // R7

    AST_RESET_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        prot_reset |-> (hv_start_en && !sw_en)); // R9

    AST_NO_DIRECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && !hv_start_en) |=> !sw_en); // R10
endmodule

bind rail_life_seq rail_life_seq_chk #(.STEP_W(STEP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rail_lt_uvlo(rail_lt_uvlo),
    .fault_req   (fault_req),
    .hv_start_en (hv_start_en),
    .sw_en       (sw_en),
    .ss_active   (ss_active),
    .ss_step     (ss_step),
    .prot_reset  (prot_reset)
);

// File: tb/rail_life_seq_tb.sv
module rail_life_seq_tb_top;
    localparam int N = 8;
    localparam int T = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, fault = 1'b0, latch = 1'b0;
    logic lt_short = 1'b1, gt_on = 1'b0, lt_uvlo = 1'b1, lt_stop = 1'b1;
    logic lt_restart = 1'b1, lt_unlatch = 1'b1;
    logic hv, hi, sw, ssa, rp;
    logic [2:0] step;

    always #5 clk = ~clk;

    rail_life_seq #(.SS_STEPS(N), .SS_TICKS_PER_STEP(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .rail_lt_short(lt_short), .rail_gt_on(gt_on), .rail_lt_uvlo(lt_uvlo),
        .rail_lt_stop(lt_stop), .rail_lt_restart(lt_restart),
        .rail_lt_unlatch(lt_unlatch), .fault_req(fault), .latch_mode(latch),
        .hv_start_en(hv), .hv_cur_hi(hi), .sw_en(sw), .ss_active(ssa),
        .ss_step(step), .prot_reset(rp)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int rail_mv = 0;

    typedef enum int {M_SLOW, M_FAST, M_SS, M_RUN, M_D1, M_D2, M_LAT} mst_e;
    mst_e ms  = M_SLOW;
    int mstep = 0, mcnt = 0;
    bit mhv = 0, mrst = 0;

    task automatic set_rail(input int mv);
        rail_mv    = mv;
        lt_short   = (mv < 2100);
        gt_on      = (mv >= 16000);
        lt_uvlo    = (mv < 7800);
        lt_stop    = (mv < 10200);
        lt_restart = (mv < 7400);
        lt_unlatch = (mv < 5000);
    endtask

    // Reference model of the requirements, one call per clock edge
    task automatic model_update();
        mst_e nxt = ms;
        int   nstep = mstep, ncnt = mcnt;
        bit   nhv = mhv, nrst = 1'b0;
        case (ms)
            M_SLOW: if (!lt_short) nxt = M_FAST;
            M_FAST: if (lt_short) nxt = M_SLOW; else if (gt_on) nxt = M_SS;
            M_SS, M_RUN: begin
                if (fault) nxt = latch ? M_LAT : M_D1;
                else if (lt_uvlo) nxt = M_D1;
                else if (ms == M_SS && tick) begin
                    if (mcnt == T - 1) begin
                        ncnt = 0;
                        if (mstep == N - 1) nxt = M_RUN; else nstep = mstep + 1;
                    end else ncnt = mcnt + 1;
                end
            end
            M_D1: if (lt_stop) nxt = M_D2;
            M_D2: if (lt_restart) begin nxt = M_SLOW; nrst = 1'b1; end
            M_LAT: begin
                if (lt_restart) nhv = 1'b1; else if (gt_on) nhv = 1'b0;
                if (lt_unlatch) begin nxt = M_SLOW; nrst = 1'b1; end
            end
            default: nxt = M_SLOW;
        endcase
        if (ms != M_SS) begin nstep = 0; ncnt = 0; end
        if (ms != M_LAT) nhv = 1'b0;
        ms = nxt; mstep = nstep; mcnt = ncnt; mhv = nhv; mrst = nrst;
    endtask

    function automatic logic [7:0] exp_vec();
        logic e_hv, e_hi, e_sw, e_ssa;
        logic [2:0] e_step;
        e_hv   = (ms == M_SLOW) || (ms == M_FAST) || (ms == M_LAT && mhv);
        e_hi   = (ms == M_FAST) || (ms == M_LAT && mhv);
        e_sw   = (ms == M_SS) || (ms == M_RUN);
        e_ssa  = (ms == M_SS);
        e_step = (ms == M_SS) ? 3'(mstep) : ((ms == M_RUN) ? 3'(N - 1) : 3'd0);
        return {e_hv, e_hi, e_sw, e_ssa, e_step, mrst};
    endfunction

    task automatic chk(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {hv, hi, sw, ssa, step, rp};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (hv,hi,sw,ss,step,rst)", req, act, exp);
        end
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        model_update();
        #1;
        chk(req, exp_vec());
    endtask

    task automatic ticks(input int n, input string req);
        tick = 1'b1;
        for (int i = 0; i < n; i++) cyc(req);
        tick = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        set_rail(0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1", 8'b1000_0000);
        cyc("R1");
        chk("R1", 8'b1000_0000);

        // Startup current selection
        set_rail(3000); cyc("R2");
        set_rail(1000); cyc("R2");
        set_rail(3000); cyc("R2");
        fault = 1'b1;   cyc("R10");
        fault = 1'b0;
        set_rail(17000); cyc("R3");
        chk("R3", 8'b0011_0000);

        // Ramp: idle cycle, then full ramp
        cyc("R4");
        ticks(N * T, "R4");
        chk("R4", 8'b0010_1110);
        set_rail(13000); cyc("R4");

        // Auto-restart fault path
        fault = 1'b1; cyc("R6");
        fault = 1'b0;
        lt_restart = 1'b1; lt_stop = 1'b0; cyc("R6");
        set_rail(9000); cyc("R6");
        fault = 1'b1; cyc("R10");
        fault = 1'b0;
        set_rail(7000); cyc("R7");
        chk("R7", 8'b1000_0001);
        cyc("R7");

        // Undervoltage lockout
        set_rail(17000); cyc("R3");
        set_rail(7700);  cyc("R5");
        cyc("R5");
        set_rail(7000);  cyc("R7");

        // Fault on the final ramp tick
        set_rail(17000); cyc("R3"); cyc("R3");
        ticks(N * T - 1, "R4");
        tick = 1'b1; fault = 1'b1; cyc("R11");
        tick = 1'b0; fault = 1'b0;
        set_rail(9000); cyc("R6");
        set_rail(7000); cyc("R7");

        // Fault together with UVLO in latch mode, then latched behaviour
        set_rail(17000); cyc("R3"); cyc("R3");
        set_rail(7700); latch = 1'b1; fault = 1'b1; cyc("R11");
        fault = 1'b0; cyc("R8");
        set_rail(7000);  cyc("R8");
        chk("R8", 8'b1100_0000);
        fault = 1'b1;    cyc("R10");
        fault = 1'b0;
        set_rail(17000); cyc("R8");
        set_rail(12000); cyc("R8");
        chk("R8", 8'b0000_0000);
        set_rail(7000);  cyc("R8");
        set_rail(4000);  cyc("R9");
        chk("R9", 8'b1000_0001);
        latch = 1'b0;

        // Constrained random rail trajectory
        for (int i = 0; i < 4000; i++) begin
            int d;
            if (i % 1000 == 500) latch = ~latch;
            if (ms == M_SS || ms == M_RUN)
                d = $urandom_range(0, 1400) - 700 + ((13000 - rail_mv) / 8);
            else if (exp_vec()[7])
                d = $urandom_range(300, 1200);
            else
                d = -$urandom_range(200, 900);
            if ($urandom_range(0, 99) == 0) d = -4000;
            rail_mv = rail_mv + d;
            if (rail_mv < 0) rail_mv = 0;
            if (rail_mv > 20000) rail_mv = 20000;
            set_rail(rail_mv);
            fault = ($urandom_range(0, 59) == 0);
            tick  = $urandom_range(0, 1);
            cyc("R11");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule